// File: doc/BRIEF.md
# Variable Page Size TLB

This block is a fully associative translation buffer that turns 32-bit effective addresses into 32-bit real addresses. It has 64 entries. Each entry holds a tag word and a data word, and software loads those words one at a time through an indexed write port. Every entry has its own page size code, which can be 1K, 4K, 16K, 64K, 256K, 1M, 4M or 16M. That code sets how many upper address bits take part in the match. The address bits below that point pass through to the real address without change.

A lookup compares its effective address with every valid entry in parallel and returns a registered result one cycle later. The result carries hit or miss, the translated address, the storage attributes, the zone select and a protection fault. A fault comes from a fetch to an entry that does not allow execution, or from a store to an entry that does not allow writes. If two or more valid entries overlap, the entry with the lowest index wins and a multi-hit flag is raised. Two inputs invalidate entries: one clears every entry at once, and the other clears every entry that covers a given address.

Top module: `vtlb`

## Requirements
- R1: After reset no entry is valid, `lk_valid_o` is low, and the first lookup reports a miss.
- R2: A write with `wr_sel_i`=0 loads the tag word: effective page number in bits 31:10, size code in bits 9:7, valid in bit 6. A write with `wr_sel_i`=1 loads the data word: real page number in bits 31:10, execute-enable in bit 9, write-enable in bit 8, zone in bits 7:4, attributes W,I,M,G in bits 3:0.
- R3: An entry whose valid bit is clear never produces a hit.
- R4: For size code s (0..7 meaning 1K, 4K, 16K, 64K, 256K, 1M, 4M, 16M), an entry matches when effective address bits 31 down to 10+2s equal its page number bits in that same range.
- R5: On a hit, `lk_ra_o` bits 31 down to 10+2s come from the real page number and the lower bits come from `lk_ea_i`.
- R6: A lookup request is answered in the following cycle. `lk_valid_o` is high in that cycle, and exactly one of `lk_hit_o` and `lk_miss_o` is high.
- R7: A hit reports `lk_fault_o` when `lk_fetch_i` is set and execute-enable is clear, or when `lk_store_i` is set and write-enable is clear. A miss never reports a fault.
- R8: When several valid entries match, the result comes from the lowest index and `lk_multi_o` is set. `lk_multi_o` is clear when one entry or no entry matches.
- R9: `inv_all_i` clears every valid bit in one cycle. This includes the valid bit of a tag written in the same cycle.
- R10: `inv_addr_en_i` clears every entry that matches `inv_addr_i` and leaves the other entries unchanged.
- R11: A lookup in the same cycle as an entry write sees the old contents. The new contents are seen from the next cycle onward.
- R12: On a hit, `lk_attr_o` and `lk_zone_o` show the winning entry's fields. On a miss, `lk_ra_o`, `lk_attr_o`, `lk_zone_o`, `lk_fault_o` and `lk_multi_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Entry word write strobe |
| wr_idx_i | input | 6 | Entry index to write |
| wr_sel_i | input | 1 | 0 selects the tag word, 1 selects the data word |
| wr_data_i | input | 32 | Word to write |
| inv_all_i | input | 1 | Clear all valid bits |
| inv_addr_en_i | input | 1 | Clear the entries that match `inv_addr_i` |
| inv_addr_i | input | 32 | Effective address used for invalidation |
| lk_req_i | input | 1 | Lookup request |
| lk_ea_i | input | 32 | Effective address to look up |
| lk_fetch_i | input | 1 | Lookup is an instruction fetch |
| lk_store_i | input | 1 | Lookup is a store |
| lk_valid_o | output | 1 | Lookup result is present |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup miss |
| lk_ra_o | output | 32 | Translated real address |
| lk_attr_o | output | 4 | W,I,M,G attributes |
| lk_zone_o | output | 4 | Zone select |
| lk_fault_o | output | 1 | Protection fault |
| lk_multi_o | output | 1 | More than one entry matched |

## Verification
Some properties are checked on every cycle by assertions. These are that miss and fault are never both set, and that hit and miss are mutually exclusive and tied to the response cycle. They also cover that a cleared valid bit never yields a match, that the chosen index is the lowest matching one, that a tag write lands as written, and that a global invalidate empties the valid bits. Other behaviour can only be shown by the bench scenarios. These include the per-size boundary of the match, the pass-through of low bits into the real address, the one-cycle visibility of a write during a lookup, and which entries an address invalidate removes.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned PN_LSB = 10;
  localparam int unsigned SZ_W   = 3;
  localparam int unsigned PN_W   = ADDR_W - PN_LSB;

  typedef struct packed {
    logic [PN_W-1:0] epn;
    logic [SZ_W-1:0] size;
    logic            valid;
    logic [5:0]      rsvd;
  } tag_t;

  typedef struct packed {
    logic [PN_W-1:0] rpn;
    logic            ex;
    logic            wr;
    logic [3:0]      zone;
    logic [3:0]      attr;
  } data_t;

  // upper bits that take part in the match for a given size code
  function automatic logic [ADDR_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
    return {ADDR_W{1'b1}} << (PN_LSB + 2 * int'(sz));
  endfunction

endpackage

// File: rtl/vtlb_entry_match.sv
module vtlb_entry_match
  import vtlb_pkg::*;
(
  input  logic [ADDR_W-1:0] ea_i,
  input  tag_t              tag_i,
  output logic              hit_o
);

  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] diff;

  always_comb begin
    mask  = page_mask(tag_i.size);
    diff  = (ea_i ^ {tag_i.epn, {PN_LSB{1'b0}}}) & mask;
    hit_o = tag_i.valid && (diff == '0);
  end

  always_comb begin
    if (!tag_i.valid) p_invalid_no_hit_r3: assert (!hit_o);
  end

endmodule

// File: rtl/vtlb_prio.sv
module vtlb_prio #(
  parameter int unsigned N     = 64,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             multi_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o   = |req_i;
  assign multi_o = |(req_i & (req_i - N'(1)));

  always_comb begin
    if (any_o) begin
      p_lowest_wins_r8: assert (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
    p_multi_count_r8: assert (multi_o == ($countones(req_i) > 1));
  end

endmodule

// File: rtl/vtlb_xlate.sv
module vtlb_xlate
  import vtlb_pkg::*;
(
  input  logic [ADDR_W-1:0] ea_i,
  input  tag_t              tag_i,
  input  data_t             data_i,
  input  logic              fetch_i,
  input  logic              store_i,
  output logic [ADDR_W-1:0] ra_o,
  output logic              perm_err_o
);

  logic [ADDR_W-1:0] mask;

  always_comb begin
    mask       = page_mask(tag_i.size);
    ra_o       = ({data_i.rpn, {PN_LSB{1'b0}}} & mask) | (ea_i & ~mask);
    perm_err_o = (fetch_i && !data_i.ex) || (store_i && !data_i.wr);
  end

endmodule

// File: rtl/vtlb.sv
module vtlb
  import vtlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 64,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              inv_all_i,
  input  logic              inv_addr_en_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  input  logic              lk_req_i,
  input  logic [ADDR_W-1:0] lk_ea_i,
  input  logic              lk_fetch_i,
  input  logic              lk_store_i,
  output logic              lk_valid_o,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic [ADDR_W-1:0] lk_ra_o,
  output logic [3:0]        lk_attr_o,
  output logic [3:0]        lk_zone_o,
  output logic              lk_fault_o,
  output logic              lk_multi_o
);

  tag_t  tag_q  [N_ENTRIES];
  data_t data_q [N_ENTRIES];

  logic [N_ENTRIES-1:0] lk_match;
  logic [N_ENTRIES-1:0] inv_match;
  logic [N_ENTRIES-1:0] valid_vec;

  // storage and per-entry compare
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    logic wr_tag, wr_dat;
    assign wr_tag       = wr_en_i && !wr_sel_i && (wr_idx_i == IDX_W'(g));
    assign wr_dat       = wr_en_i &&  wr_sel_i && (wr_idx_i == IDX_W'(g));
    assign valid_vec[g] = tag_q[g].valid;

    vtlb_entry_match u_lk_cmp (
      .ea_i  (lk_ea_i),
      .tag_i (tag_q[g]),
      .hit_o (lk_match[g])
    );

    vtlb_entry_match u_inv_cmp (
      .ea_i  (inv_addr_i),
      .tag_i (tag_q[g]),
      .hit_o (inv_match[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g] <= '0;
      end else if (wr_tag) begin
        tag_q[g]       <= tag_t'(wr_data_i);
        tag_q[g].valid <= wr_data_i[6] && !inv_all_i;   // global clear wins
      end else if (inv_all_i || (inv_addr_en_i && inv_match[g])) begin
        tag_q[g].valid <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     data_q[g] <= '0;
      else if (wr_dat) data_q[g] <= data_t'(wr_data_i);
    end
  end

  // winner selection
  logic [IDX_W-1:0]  win_idx;
  logic              any_hit, multi_hit, perm_err;
  logic [ADDR_W-1:0] xl_ra;
  tag_t              win_tag;
  data_t             win_data;

  vtlb_prio #(.N(N_ENTRIES)) u_prio (
    .req_i   (lk_match),
    .idx_o   (win_idx),
    .any_o   (any_hit),
    .multi_o (multi_hit)
  );

  assign win_tag  = tag_q[win_idx];
  assign win_data = data_q[win_idx];

  vtlb_xlate u_xlate (
    .ea_i       (lk_ea_i),
    .tag_i      (win_tag),
    .data_i     (win_data),
    .fetch_i    (lk_fetch_i),
    .store_i    (lk_store_i),
    .ra_o       (xl_ra),
    .perm_err_o (perm_err)
  );

  // response register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_miss_o  <= 1'b0;
      lk_ra_o    <= '0;
      lk_attr_o  <= '0;
      lk_zone_o  <= '0;
      lk_fault_o <= 1'b0;
      lk_multi_o <= 1'b0;
    end else begin
      lk_valid_o <= lk_req_i;
      lk_hit_o   <= lk_req_i && any_hit;
      lk_miss_o  <= lk_req_i && !any_hit;
      if (lk_req_i && any_hit) begin
        lk_ra_o    <= xl_ra;
        lk_attr_o  <= win_data.attr;
        lk_zone_o  <= win_data.zone;
        lk_fault_o <= perm_err;
        lk_multi_o <= multi_hit;
      end else begin
        lk_ra_o    <= '0;
        lk_attr_o  <= '0;
        lk_zone_o  <= '0;
        lk_fault_o <= 1'b0;
        lk_multi_o <= 1'b0;
      end
    end
  end

  p_resp_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> lk_valid_o);
  p_hit_xor_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_o |-> (lk_hit_o ^ lk_miss_o));
  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_o |-> (!lk_hit_o && !lk_miss_o));
  p_miss_no_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_miss_o |-> !lk_fault_o);
  p_multi_needs_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_multi_o |-> lk_hit_o);
  p_miss_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_miss_o |-> (lk_ra_o == '0 && lk_attr_o == '0 && lk_zone_o == '0));
  p_inv_all_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> (valid_vec == '0));
  p_tag_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && !inv_all_i) |=> (tag_q[$past(wr_idx_i)] == tag_t'($past(wr_data_i))));

endmodule

// File: tb/vtlb_bench.sv
`timescale 1ns/1ps
module vtlb_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 0;
  logic [5:0]  wr_idx_i = '0;
  logic        wr_sel_i = 0;
  logic [31:0] wr_data_i = '0;
  logic        inv_all_i = 0;
  logic        inv_addr_en_i = 0;
  logic [31:0] inv_addr_i = '0;
  logic        lk_req_i = 0;
  logic [31:0] lk_ea_i = '0;
  logic        lk_fetch_i = 0;
  logic        lk_store_i = 0;
  logic        lk_valid_o, lk_hit_o, lk_miss_o, lk_fault_o, lk_multi_o;
  logic [31:0] lk_ra_o;
  logic [3:0]  lk_attr_o, lk_zone_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk_i = ~clk_i;

  vtlb u_vtlb (.*);

  logic [31:0] m_tag  [64];
  logic [31:0] m_data [64];

  function automatic logic [31:0] mk_tag(logic [31:0] a, logic [2:0] s, logic v);
    return {a[31:10], s, v, 6'b0};
  endfunction
  function automatic logic [31:0] mk_data(logic [31:0] a, logic ex, logic wr,
                                          logic [3:0] z, logic [3:0] at);
    return {a[31:10], ex, wr, z, at};
  endfunction
  function automatic logic [31:0] msk(logic [2:0] s);
    return 32'hFFFF_FFFF << (10 + 2 * int'(s));
  endfunction
  function automatic bit m_match(int i, logic [31:0] ea);
    return m_tag[i][6] && (((ea ^ m_tag[i]) & msk(m_tag[i][9:7])) == 0);
  endfunction

  logic        e_hit, e_multi, e_fault;
  logic [31:0] e_ra;
  logic [3:0]  e_attr, e_zone;

  task automatic model_lookup();
    int w = -1;
    int n = 0;
    for (int i = 0; i < 64; i++) if (m_match(i, lk_ea_i)) begin
      if (w < 0) w = i;
      n++;
    end
    e_hit = (w >= 0); e_multi = (n > 1);
    e_ra = '0; e_attr = '0; e_zone = '0; e_fault = 0;
    if (e_hit) begin
      e_ra    = ({m_data[w][31:10], 10'b0} & msk(m_tag[w][9:7])) | (lk_ea_i & ~msk(m_tag[w][9:7]));
      e_attr  = m_data[w][3:0];
      e_zone  = m_data[w][7:4];
      e_fault = (lk_fetch_i && !m_data[w][9]) || (lk_store_i && !m_data[w][8]);
    end
  endtask

  task automatic model_update();
    bit clr [64];
    for (int i = 0; i < 64; i++) clr[i] = inv_all_i || (inv_addr_en_i && m_match(i, inv_addr_i));
    for (int i = 0; i < 64; i++) if (clr[i]) m_tag[i][6] = 1'b0;
    if (wr_en_i && wr_sel_i) m_data[wr_idx_i] = wr_data_i;
    if (wr_en_i && !wr_sel_i) begin
      m_tag[wr_idx_i] = wr_data_i;
      if (inv_all_i) m_tag[wr_idx_i][6] = 1'b0;
    end
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock: expected from pre-update model, then compare at next negedge
  task automatic step(string req);
    bit had = lk_req_i;
    if (had) model_lookup();
    model_update();
    @(posedge clk_i); @(negedge clk_i);
    if (had) begin
      chk(lk_valid_o === 1'b1, {req, " R6 valid"}, 32'(lk_valid_o), 1);
      chk(lk_hit_o === e_hit,  {req, " R6 hit"},   32'(lk_hit_o), 32'(e_hit));
      chk(lk_miss_o === !e_hit, {req, " R6 miss"}, 32'(lk_miss_o), 32'(!e_hit));
      chk(lk_ra_o === e_ra,    {req, " R5 ra"},    lk_ra_o, e_ra);
      chk(lk_attr_o === e_attr, {req, " R12 attr"}, 32'(lk_attr_o), 32'(e_attr));
      chk(lk_zone_o === e_zone, {req, " R12 zone"}, 32'(lk_zone_o), 32'(e_zone));
      chk(lk_fault_o === e_fault, {req, " R7 fault"}, 32'(lk_fault_o), 32'(e_fault));
      chk(lk_multi_o === e_multi, {req, " R8 multi"}, 32'(lk_multi_o), 32'(e_multi));
    end else begin
      chk(lk_valid_o === 1'b0, {req, " R6 idle"}, 32'(lk_valid_o), 0);
    end
    wr_en_i = 0; inv_all_i = 0; inv_addr_en_i = 0; lk_req_i = 0;
    lk_fetch_i = 0; lk_store_i = 0;
  endtask

  task automatic wr(int idx, bit sel, logic [31:0] d, string req);
    wr_en_i = 1; wr_idx_i = 6'(idx); wr_sel_i = sel; wr_data_i = d;
    step(req);
  endtask

  task automatic look(logic [31:0] ea, bit f, bit s, string req);
    lk_req_i = 1; lk_ea_i = ea; lk_fetch_i = f; lk_store_i = s;
    step(req);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_data[i] = '0; end
    repeat (3) @(negedge clk_i);
    chk(lk_valid_o === 0 && lk_hit_o === 0, "R1 reset outputs", 32'(lk_valid_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    look(32'h048D_1555, 0, 0, "R1 first lookup");
    chk(lk_miss_o === 1, "R1 miss after reset", 32'(lk_miss_o), 1);

    // R2 / R5 / R12 on a 1K page
    wr(5, 1, mk_data(32'h0AAF_3400, 1, 0, 4'h3, 4'hA), "R2 data");
    wr(5, 0, mk_tag(32'h048D_1400, 3'd0, 1), "R2 tag");
    look(32'h048D_1555, 1, 0, "R2 fetch");
    chk(lk_ra_o === 32'h0AAF_3555, "R5 1K ra", lk_ra_o, 32'h0AAF_3555);
    chk(lk_zone_o === 4'h3 && lk_attr_o === 4'hA, "R12 fields", {24'b0, lk_zone_o, lk_attr_o}, 32'h3A);
    chk(lk_fault_o === 0, "R7 exec ok", 32'(lk_fault_o), 0);
    look(32'h048D_1400, 0, 1, "R7 store");
    chk(lk_fault_o === 1 && lk_hit_o === 1, "R7 store fault", 32'(lk_fault_o), 1);

    // R4 16M page boundary
    wr(6, 1, mk_data(32'h1200_0000, 0, 1, 4'h1, 4'h5), "R4 data");
    wr(6, 0, mk_tag(32'hA500_0000, 3'd7, 1), "R4 tag");
    look(32'hA5FF_FFFF, 0, 1, "R4 inside");
    chk(lk_hit_o === 1 && lk_ra_o === 32'h12FF_FFFF, "R4 16M hit", lk_ra_o, 32'h12FF_FFFF);
    look(32'hA4FF_FFFF, 0, 0, "R4 outside");
    chk(lk_miss_o === 1, "R4 16M miss", 32'(lk_miss_o), 1);
    look(32'hA5FF_FFFF, 1, 0, "R7 fetch noexec");
    chk(lk_fault_o === 1, "R7 fetch fault", 32'(lk_fault_o), 1);

    // R3 invalid entry
    wr(30, 0, mk_tag(32'h8000_0000, 3'd0, 0), "R3 tag");
    look(32'h8000_0000, 0, 0, "R3 lookup");
    chk(lk_miss_o === 1, "R3 invalid miss", 32'(lk_miss_o), 1);

    // R8 overlapping entries
    wr(20, 1, mk_data(32'h0011_1000, 1, 1, 4'h2, 4'h2), "R8 d20");
    wr(20, 0, mk_tag(32'h7000_0000, 3'd1, 1), "R8 t20");
    wr(9, 1, mk_data(32'h0022_2000, 1, 1, 4'h4, 4'h4), "R8 d9");
    wr(9, 0, mk_tag(32'h7000_0000, 3'd1, 1), "R8 t9");
    look(32'h7000_0123, 0, 0, "R8 lookup");
    chk(lk_multi_o === 1 && lk_ra_o === 32'h0022_2123, "R8 lowest wins", lk_ra_o, 32'h0022_2123);

    // R11 write concurrent with lookup
    wr(40, 1, mk_data(32'h0033_3000, 1, 1, 4'h0, 4'h0), "R11 data");
    wr_en_i = 1; wr_idx_i = 6'd40; wr_sel_i = 0; wr_data_i = mk_tag(32'h9000_0000, 3'd0, 1);
    look(32'h9000_0040, 0, 0, "R11 same cycle");
    chk(lk_miss_o === 1, "R11 old contents", 32'(lk_miss_o), 1);
    look(32'h9000_0040, 0, 0, "R11 next cycle");
    chk(lk_hit_o === 1, "R11 new contents", 32'(lk_hit_o), 1);

    // R10 invalidate by address
    inv_addr_en_i = 1; inv_addr_i = 32'h7000_0ABC; step("R10 inv");
    look(32'h7000_0123, 0, 0, "R10 gone");
    chk(lk_miss_o === 1, "R10 cleared", 32'(lk_miss_o), 1);
    look(32'h048D_1555, 1, 0, "R10 kept");
    chk(lk_hit_o === 1, "R10 untouched", 32'(lk_hit_o), 1);

    // R9 invalidate all with concurrent tag write
    inv_all_i = 1;
    wr(50, 0, mk_tag(32'hC000_0000, 3'd2, 1), "R9 inv+write");
    look(32'hC000_0000, 0, 0, "R9 written");
    chk(lk_miss_o === 1, "R9 write cleared", 32'(lk_miss_o), 1);
    look(32'h048D_1555, 0, 0, "R9 old");
    chk(lk_miss_o === 1, "R9 all cleared", 32'(lk_miss_o), 1);

    // constrained random
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 999);
      if (r < 400) begin
        wr_en_i = 1; wr_idx_i = 6'($urandom_range(0, 63)); wr_sel_i = $urandom_range(0, 1);
        wr_data_i = $urandom;
        if (!wr_sel_i) begin
          wr_data_i[31:28] = 4'($urandom_range(0, 3));
          wr_data_i[6] = ($urandom_range(0, 9) != 0);
        end
      end
      if (r > 300) begin
        lk_req_i = 1; lk_fetch_i = $urandom_range(0, 1); lk_store_i = $urandom_range(0, 1);
        if ($urandom_range(0, 9) < 7)
          lk_ea_i = (m_tag[$urandom_range(0, 63)] & 32'hFFFF_FC00) ^ ($urandom & 32'h00FF_FFFF >> $urandom_range(0, 14));
        else
          lk_ea_i = $urandom & 32'h3FFF_FFFF;
      end
      if (r < 15) begin inv_addr_en_i = 1; inv_addr_i = m_tag[$urandom_range(0, 63)]; end
      if (r == 999) inv_all_i = 1;
      step("R4 R5 R7 R8 R10 random");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule